// File: doc/BRIEF.md
# Short-Circuit Hiccup Protection Controller

This controller protects a power converter against a shorted output rail. A comparator flag reports that the rail has fallen below its undervoltage level. The controller filters that flag over a number of millisecond ticks. Once the condition is confirmed, it either latches the converter off at once or runs a hiccup sequence. In that sequence the converter is held off for a long rest period and then enabled for a short trial. Restarts that fail are counted inside a window that opens at the first failure. When the count reaches its limit, the converter is latched off.

While the rail is low, the controller also selects a reduced input-current limit. The level depends on whether the input supply is in its high range. A small register interface lets the host disable protection, disable hiccup retries, and clear a latched fault. The fault bit is write-to-clear: writing 0 clears it and writing 1 has no effect. The fault is reported both as a status bit and on an active-low pin.

Top module: `shp_ctrl`

## Requirements
- R1: After reset, conv_en=1, fault_stat=0, stat_n=1, clamp_sel=2'b00, and both configuration readbacks read 0 (protection and hiccup enabled).
- R2: An undervoltage flag that holds for fewer than DEG_MS consecutive ms_tick pulses is ignored. The count restarts whenever rail_low drops, and cycles without a tick do not advance it. After DEG_MS ticks the fault is confirmed and conv_en falls on the next clock.
- R3: clamp_sel is 2'b01 (0.5 A level) while rail_low=1 and vin_high=0, and 2'b10 (0.3 A level) while rail_low=1 and vin_high=1. It is 2'b00 otherwise. This holds with or without a declared fault.
- R4: In hiccup mode a confirmed fault holds conv_en=0 for exactly OFF_MS ticks, then raises conv_en for a trial of exactly TRIAL_MS ticks.
- R5: A trial that ends with rail_low=0 returns to normal operation with conv_en=1 and clears the failure count.
- R6: A trial that ends with rail_low=1 is a failed restart. It re-enters the off period, and the fault bit stays 0 while the count is below FAIL_LIMIT.
- R7: When FAIL_LIMIT failed restarts occur inside the window, the converter latches off: conv_en=0, fault_stat=1, stat_n=0.
- R8: The window lasts WIN_MS ticks from the first failure. If it expires before the limit is reached, the count restarts from zero.
- R9: With the hiccup-disable bit set, a confirmed fault latches off directly, with no off/trial bursts.
- R10: A register write with cfg_fault_wr=0 clears a latched fault: conv_en=1 and stat_n=1 on the next cycle. A write with cfg_fault_wr=1 leaves the fault in place.
- R11: With the protection-disable bit set, no clamp is selected and no fault is declared. Setting that bit while a fault is latched does not clear the fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| rail_low | input | 1 | Rail below undervoltage threshold |
| vin_high | input | 1 | Input supply above its high range |
| cfg_we | input | 1 | Register write strobe |
| cfg_prot_dis | input | 1 | Write data: protection disable |
| cfg_hic_dis | input | 1 | Write data: hiccup disable |
| cfg_fault_wr | input | 1 | Write data: fault bit (0 clears) |
| conv_en | output | 1 | Converter enable |
| clamp_sel | output | 2 | Current-limit clamp select |
| fault_stat | output | 1 | Latched fault status bit |
| stat_n | output | 1 | Active-low fault status pin |
| prot_dis_o | output | 1 | Readback of protection disable |
| hic_dis_o | output | 1 | Readback of hiccup disable |

## Verification
The bench drives the undervoltage flag in several patterns:
- A pulse shorter than the filter, and a long low period with ticks withheld. Together these separate a tick-counted filter from a cycle-counted one.
- A persistent short that fails every trial, which must latch after the limit.
- Failures broken up by a passing trial, which must never latch because the count restarts.
- On a second instance with a window shorter than the failure spacing, a persistent short that shows window expiry.

The latch-off path is exercised with hiccup on and with hiccup off. It is also checked against writes of 1 to the fault bit and against disabling protection while latched.

// File: rtl/shp_pkg.sv
package shp_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_OFF   = 2'd1,
        ST_TRIAL = 2'd2,
        ST_LATCH = 2'd3
    } shp_state_e;

    localparam logic [1:0] CLAMP_NONE  = 2'b00;
    localparam logic [1:0] CLAMP_500MA = 2'b01;
    localparam logic [1:0] CLAMP_300MA = 2'b10;
endpackage

// File: rtl/shp_deglitch.sv
module shp_deglitch #(
    parameter int DEG_MS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic low_i,
    input  logic tick_i,
    output logic conf_o
);
    localparam int CW = $clog2(DEG_MS + 1);
    localparam logic [CW-1:0] CMAX = CW'(DEG_MS);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } deg_t;

    deg_t d, q;

    always_comb begin
        d = q;
        if (!arm_i || !low_i) begin
            d.cnt = '0;
        end else if (tick_i && q.cnt != CMAX) begin
            d.cnt = q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign conf_o = (q.cnt == CMAX);

    // R2: a released flag always wipes the filter count
    p_deg_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !low_i |=> (q.cnt == '0));
endmodule

// File: rtl/shp_fail_window.sv
module shp_fail_window #(
    parameter int FAIL_LIMIT = 7,
    parameter int WIN_MS     = 90000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic fail_i,
    input  logic tick_i,
    output logic near_o
);
    localparam int CW = $clog2(FAIL_LIMIT + 1);
    localparam int TW = $clog2(WIN_MS + 1);
    localparam logic [CW-1:0] LIM  = CW'(FAIL_LIMIT);
    localparam logic [TW-1:0] TEND = TW'(WIN_MS - 1);

    typedef struct packed {
        logic          active;
        logic [CW-1:0] cnt;
        logic [TW-1:0] tmr;
    } win_t;

    win_t d, q;
    logic expire;

    assign expire = q.active && tick_i && (q.tmr == TEND);

    always_comb begin
        d = q;
        if (expire) begin
            d = '0;
        end else if (q.active && tick_i) begin
            d.tmr = q.tmr + TW'(1);
        end
        if (fail_i) begin
            if (!q.active || expire) begin
                d.active = 1'b1;
                d.cnt    = CW'(1);
                d.tmr    = '0;
            end else if (q.cnt != LIM) begin
                d.cnt = q.cnt + CW'(1);
            end
        end
        if (clr_i) d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // the next failure would reach the limit
    assign near_o = (q.active && !expire) ? ((q.cnt + CW'(1)) >= LIM)
                                          : (FAIL_LIMIT <= 1);

    // R8: failure count never exceeds the limit and is zero while idle
    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cnt <= LIM) && (q.active || q.cnt == '0));
endmodule

// File: rtl/shp_sequencer.sv
module shp_sequencer
    import shp_pkg::*;
#(
    parameter int OFF_MS   = 500,
    parameter int TRIAL_MS = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       prot_en_i,
    input  logic       hic_dis_i,
    input  logic       uv_conf_i,
    input  logic       rail_low_i,
    input  logic       tick_i,
    input  logic       fault_clr_i,
    input  logic       near_i,
    output shp_state_e state_o,
    output logic       fail_o,
    output logic       win_clr_o,
    output logic       deg_arm_o
);
    localparam int TMAX = (OFF_MS > TRIAL_MS) ? OFF_MS : TRIAL_MS;
    localparam int TW   = $clog2(TMAX + 1);
    localparam logic [TW-1:0] OFF_END   = TW'(OFF_MS - 1);
    localparam logic [TW-1:0] TRIAL_END = TW'(TRIAL_MS - 1);

    typedef struct packed {
        shp_state_e    st;
        logic [TW-1:0] tmr;
    } seq_t;

    seq_t d, q;
    logic pass;

    always_comb begin
        d      = q;
        fail_o = 1'b0;
        pass   = 1'b0;
        unique case (q.st)
            ST_RUN: begin
                d.tmr = '0;
                if (prot_en_i && uv_conf_i) begin
                    d.st = hic_dis_i ? ST_LATCH : ST_OFF;
                end
            end
            ST_OFF: begin
                if (!prot_en_i) begin
                    d.st  = ST_RUN;
                    d.tmr = '0;
                end else if (tick_i) begin
                    if (q.tmr == OFF_END) begin
                        d.st  = ST_TRIAL;
                        d.tmr = '0;
                    end else begin
                        d.tmr = q.tmr + TW'(1);
                    end
                end
            end
            ST_TRIAL: begin
                if (!prot_en_i) begin
                    d.st  = ST_RUN;
                    d.tmr = '0;
                end else if (tick_i) begin
                    if (q.tmr == TRIAL_END) begin
                        d.tmr = '0;
                        if (rail_low_i) begin
                            fail_o = 1'b1;
                            d.st   = near_i ? ST_LATCH : ST_OFF;
                        end else begin
                            pass = 1'b1;
                            d.st = ST_RUN;
                        end
                    end else begin
                        d.tmr = q.tmr + TW'(1);
                    end
                end
            end
            ST_LATCH: begin
                d.tmr = '0;
                if (fault_clr_i) d.st = ST_RUN;
            end
            default: d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_RUN, tmr: '0};
        else        q <= d;
    end

    assign state_o   = q.st;
    assign win_clr_o = pass || !prot_en_i || (q.st == ST_LATCH);
    assign deg_arm_o = prot_en_i && (q.st == ST_RUN);

    // R2: normal operation is only left on a filtered fault
    p_leave_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RUN && d.st != ST_RUN) |-> uv_conf_i);

    // R4: off period holds until its timer reaches the end
    p_off_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_OFF && prot_en_i && q.tmr != OFF_END) |=> (q.st == ST_OFF));

    // R10: latch persists until a clearing write
    p_latch_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_LATCH && !fault_clr_i) |=> (q.st == ST_LATCH));
endmodule

// File: rtl/shp_ctrl.sv
module shp_ctrl
    import shp_pkg::*;
#(
    parameter int DEG_MS     = 2,
    parameter int OFF_MS     = 500,
    parameter int TRIAL_MS   = 10,
    parameter int WIN_MS     = 90000,
    parameter int FAIL_LIMIT = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ms_tick,
    input  logic       rail_low,
    input  logic       vin_high,
    input  logic       cfg_we,
    input  logic       cfg_prot_dis,
    input  logic       cfg_hic_dis,
    input  logic       cfg_fault_wr,
    output logic       conv_en,
    output logic [1:0] clamp_sel,
    output logic       fault_stat,
    output logic       stat_n,
    output logic       prot_dis_o,
    output logic       hic_dis_o
);
    typedef struct packed {
        logic prot_dis;
        logic hic_dis;
    } cfg_t;

    cfg_t       cfg_d, cfg_q;
    shp_state_e st;
    logic       uv_conf, deg_arm, fail, win_clr, near, fault_clr, prot_en;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            cfg_d.prot_dis = cfg_prot_dis;
            cfg_d.hic_dis  = cfg_hic_dis;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign prot_en   = !cfg_q.prot_dis;
    assign fault_clr = cfg_we && !cfg_fault_wr;

    shp_deglitch #(.DEG_MS(DEG_MS)) u_deg (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm_i  (deg_arm),
        .low_i  (rail_low),
        .tick_i (ms_tick),
        .conf_o (uv_conf)
    );

    shp_fail_window #(.FAIL_LIMIT(FAIL_LIMIT), .WIN_MS(WIN_MS)) u_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (win_clr),
        .fail_i (fail),
        .tick_i (ms_tick),
        .near_o (near)
    );

    shp_sequencer #(.OFF_MS(OFF_MS), .TRIAL_MS(TRIAL_MS)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .prot_en_i   (prot_en),
        .hic_dis_i   (cfg_q.hic_dis),
        .uv_conf_i   (uv_conf),
        .rail_low_i  (rail_low),
        .tick_i      (ms_tick),
        .fault_clr_i (fault_clr),
        .near_i      (near),
        .state_o     (st),
        .fail_o      (fail),
        .win_clr_o   (win_clr),
        .deg_arm_o   (deg_arm)
    );

    always_comb begin
        clamp_sel = CLAMP_NONE;
        if (prot_en && rail_low) clamp_sel = vin_high ? CLAMP_300MA : CLAMP_500MA;
    end

    assign conv_en    = (st == ST_RUN) || (st == ST_TRIAL);
    assign fault_stat = (st == ST_LATCH);
    assign stat_n     = !fault_stat;
    assign prot_dis_o = cfg_q.prot_dis;
    assign hic_dis_o  = cfg_q.hic_dis;

    // R10: a clearing write releases converter and pin on the next cycle
    p_clear_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_stat && cfg_we && !cfg_fault_wr) |=> (conv_en && stat_n));

    // R7: a fault can only appear while protection is enabled
    p_fault_needs_prot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_stat) |-> $past(prot_en));
endmodule

// File: tb/shp_ctrl_test.sv
module shp_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEG   = 3;
    localparam int OFFT  = 4;
    localparam int TRIAL = 2;
    localparam int LIMIT = 3;

    logic clk = 0, rst_n = 0, tick = 1, rail = 0, vhi = 0;
    logic we = 0, wpd = 0, whd = 0, wf = 1;
    logic conv_en, fault_stat, stat_n, pd_o, hd_o;
    logic [1:0] clamp;
    logic rail_w = 0, conv_w, fault_w, stat_w, pdw, hdw;
    logic [1:0] clamp_w;
    int errs = 0, checks = 0, cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shp_ctrl #(.DEG_MS(DEG), .OFF_MS(OFFT), .TRIAL_MS(TRIAL), .WIN_MS(20), .FAIL_LIMIT(LIMIT)) uut (
        .clk(clk), .rst_n(rst_n), .ms_tick(tick), .rail_low(rail), .vin_high(vhi),
        .cfg_we(we), .cfg_prot_dis(wpd), .cfg_hic_dis(whd), .cfg_fault_wr(wf),
        .conv_en(conv_en), .clamp_sel(clamp), .fault_stat(fault_stat), .stat_n(stat_n),
        .prot_dis_o(pd_o), .hic_dis_o(hd_o));

    shp_ctrl #(.DEG_MS(DEG), .OFF_MS(OFFT), .TRIAL_MS(TRIAL), .WIN_MS(10), .FAIL_LIMIT(LIMIT)) uut_win (
        .clk(clk), .rst_n(rst_n), .ms_tick(tick), .rail_low(rail_w), .vin_high(1'b0),
        .cfg_we(1'b0), .cfg_prot_dis(1'b0), .cfg_hic_dis(1'b0), .cfg_fault_wr(1'b1),
        .conv_en(conv_w), .clamp_sel(clamp_w), .fault_stat(fault_w), .stat_n(stat_w),
        .prot_dis_o(pdw), .hic_dis_o(hdw));

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(logic pd, logic hd, logic f);
        wpd = pd; whd = hd; wf = f; we = 1;
        step();
        we = 0; wf = 1;
    endtask

    task automatic count_while(logic lvl, output int n);
        n = 0;
        while (conv_en == lvl && n < 1000) begin step(); n++; end
    endtask

    task automatic t_reset();
        chk("R1 conv_en", conv_en, 1);
        chk("R1 fault", fault_stat, 0);
        chk("R1 stat_n", stat_n, 1);
        chk("R1 clamp", clamp, 0);
        chk("R1 readback", {pd_o, hd_o}, 0);
    endtask

    task automatic t_clamp();
        rail = 1; vhi = 0; #1;
        chk("R3 clamp 0.5A", clamp, 1);
        vhi = 1; #1;
        chk("R3 clamp 0.3A", clamp, 2);
        rail = 0; #1;
        chk("R3 clamp off", clamp, 0);
        vhi = 0;
    endtask

    task automatic t_glitch();
        rail = 1;
        repeat (DEG - 1) step();
        rail = 0; step();
        rail = 1;
        repeat (DEG - 1) step();
        rail = 0;
        repeat (3) step();
        chk("R2 short pulses ignored", conv_en, 1);
        tick = 0; rail = 1;
        repeat (12) step();
        chk("R2 no count without tick", conv_en, 1);
        rail = 0; tick = 1;
        step();
    endtask

    task automatic t_recover();
        int n;
        rail = 1;
        count_while(1'b1, n);
        chk("R2 confirm latency", n, DEG + 1);
        for (int round = 0; round < 2; round++) begin
            for (int k = 0; k < LIMIT - 1; k++) begin
                count_while(1'b0, n);
                if (round == 0 && k == 0) chk("R4 off length", n, OFFT);
                count_while(1'b1, n);
                if (round == 0 && k == 0) chk("R4 trial length", n, TRIAL);
                chk("R6 no fault below limit", fault_stat, 0);
            end
            count_while(1'b0, n);
            rail = 0;
            repeat (TRIAL + 3) step();
            chk("R5 passed trial keeps running", conv_en, 1);
            if (round == 0) begin
                rail = 1;
                count_while(1'b1, n);
            end
        end
        chk("R5 count cleared by pass", fault_stat, 0);
    endtask

    task automatic t_latch();
        int n, trials;
        trials = 0;
        rail = 1;
        count_while(1'b1, n);
        while (!fault_stat && trials < 10) begin
            count_while(1'b0, n);
            if (fault_stat) break;
            trials++;
            count_while(1'b1, n);
        end
        chk("R7 trials before latch", trials, LIMIT);
        chk("R7 fault bit", fault_stat, 1);
        chk("R7 stat pin", stat_n, 0);
        chk("R7 conv off", conv_en, 0);
        rail = 0;
        wr(1'b0, 1'b0, 1'b1);
        step();
        chk("R10 write 1 keeps fault", fault_stat, 1);
        wr(1'b1, 1'b0, 1'b1);
        step();
        chk("R11 disable keeps fault", fault_stat, 1);
        chk("R11 disable readback", pd_o, 1);
        wr(1'b0, 1'b0, 1'b1);
        wr(1'b0, 1'b0, 1'b0);
        chk("R10 clear conv_en", conv_en, 1);
        chk("R10 clear stat pin", stat_n, 1);
        chk("R10 clear fault", fault_stat, 0);
    endtask

    task automatic t_no_hiccup();
        int n;
        wr(1'b0, 1'b1, 1'b1);
        chk("R9 readback", hd_o, 1);
        rail = 1;
        count_while(1'b1, n);
        chk("R9 confirm latency", n, DEG + 1);
        chk("R9 direct latch", fault_stat, 1);
        repeat (OFFT + TRIAL + 2) step();
        chk("R9 no retry", conv_en, 0);
        rail = 0;
        wr(1'b0, 1'b0, 1'b0);
        chk("R10 clear after direct latch", stat_n, 1);
    endtask

    task automatic t_disable();
        wr(1'b1, 1'b0, 1'b1);
        rail = 1; vhi = 1;
        repeat (30) step();
        chk("R11 no clamp when disabled", clamp, 0);
        chk("R11 no fault when disabled", fault_stat, 0);
        chk("R11 conv stays on", conv_en, 1);
        rail = 0; vhi = 0;
        wr(1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_window();
        int rises;
        logic prev;
        rises = 0; prev = conv_w;
        rail_w = 1;
        for (int i = 0; i < 100; i++) begin
            step();
            if (conv_w && !prev) rises++;
            prev = conv_w;
            if (fault_w) break;
        end
        chk("R8 expiry prevents latch", fault_w, 0);
        chk("R8 retries continue", (rises > LIMIT) ? 1 : 0, 1);
        rail_w = 0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errs++; checks++;
            $display("FAIL watchdog: got %0d expected below %0d", cyc, 20000);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (2) step();
        rst_n = 1;
        step();
        t_reset();
        t_clamp();
        t_glitch();
        t_recover();
        repeat (3) step();
        t_latch();
        repeat (3) step();
        t_no_hiccup();
        repeat (3) step();
        t_disable();
        t_window();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule